// File: doc/BRIEF.md
# CPU Bus Cycle Strobe Generator

This block turns a master clock into the bus cycles of a 16-bit processor with a 24-bit address space, and drives the memory read and write strobes for those cycles. Each CPU cycle lasts a whole number of master clocks. The length is chosen when the cycle begins and depends on the kind of access. Fast memory gets short cycles. Slow memory gets long cycles. DMA transfers use their own timing. The block produces the phase clock PHI2, which is low at the start of each cycle and high at the end. The strobe window lies inside the high phase.

The processor puts its bank byte on the data bus during the low phase. The block samples that byte on every master clock while PHI2 is low, and holds it while PHI2 is high. It then joins the bank with the 16-bit offset to form the full address.

A strobe is given only for a real memory cycle, that is, one in which at least one of the two address-valid qualifiers is set. An internal-operation cycle produces no strobe, even when the direction line says read. Chip-select decoding and arbitration between the CPU and DMA belong to the surrounding logic.

Top module: `cpu_bus_strobe_gen`

## Requirements
- R1: During and directly after synchronous reset, PHI2 is low, both strobes are high and the bank output is 0. The first cycle after reset has slow timing: 5 clocks low, then 3 clocks high.
- R2: When the fast flag is 1 and the DMA flag is 0 at a cycle's start, the cycle lasts 6 master clocks: PHI2 is low for 3 and high for 3.
- R3: When both flags are 0 at a cycle's start, the cycle lasts 8 master clocks: PHI2 is low for 5 and high for 3.
- R4: When the DMA flag is 1 at a cycle's start, whatever the fast flag, the cycle lasts 8 master clocks: PHI2 is low for 4 and high for 4.
- R5: The flags are sampled only at the clock edge that begins a cycle. A change in the middle of a cycle leaves that cycle's length unchanged and takes effect in the next cycle.
- R6: The read strobe rd_n_o goes low (active) only while PHI2 is high, rwb_i is 1 and vda_i or vpa_i is 1. It stays low for the whole high phase of such a cycle.
- R7: The write strobe wr_n_o goes low (active) only while PHI2 is high, rwb_i is 0 and vda_i or vpa_i is 1. It stays low for the whole high phase of such a cycle.
- R8: A cycle with vda_i = 0 and vpa_i = 0 is an internal operation. Neither strobe goes low in it, whatever the value of rwb_i.
- R9: On each master clock edge at which PHI2 is low, bank_o takes the value on data_i. While PHI2 is high, bank_o holds.
- R10: addr_o carries bank_o in bits 23:16 and offset_i in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rwb_i | input | 1 | Direction: 1 = read, 0 = write |
| vda_i | input | 1 | Data address valid qualifier |
| vpa_i | input | 1 | Program address valid qualifier |
| offset_i | input | 16 | Low 16 address bits |
| data_i | input | 8 | Data bus; carries the bank byte during PHI2 low |
| fast_i | input | 1 | Access targets the fast memory region |
| dma_i | input | 1 | A DMA transfer is in progress |
| phi2_o | output | 1 | CPU phase clock |
| bank_o | output | 8 | Latched bank byte |
| addr_o | output | 24 | Full address {bank, offset} |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters. These give a 6-clock fast cycle split 3/3, an 8-clock slow cycle split 5/3 and an 8-clock DMA cycle split 4/4. With these values all three phase splits can be measured directly at PHI2. Changing the flags in the middle of a cycle shows the boundary at which the length is sampled. Sampling the bank over a low-to-high-to-low PHI2 sequence shows the one-clock delay before the bank latch tracks the data bus again.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        CYC_SLOW = 2'd0,
        CYC_FAST = 2'd1,
        CYC_DMA  = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } strobe_t;

    // DMA timing wins over the fast-region flag.
    function automatic cyc_kind_e pick_kind(input logic fast, input logic dma);
        if (dma) begin
            return CYC_DMA;
        end else if (fast) begin
            return CYC_FAST;
        end
        return CYC_SLOW;
    endfunction

endpackage

// File: rtl/cbs_cycle_timer.sv
module cbs_cycle_timer
    import cbs_pkg::*;
#(
    parameter int FAST_LEN = 6,
    parameter int FAST_ACT = 3,
    parameter int SLOW_LEN = 8,
    parameter int SLOW_ACT = 3,
    parameter int DMA_LEN  = 8,
    parameter int DMA_ACT  = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fast_i,
    input  logic dma_i,
    output logic phi2_o
);

    localparam int MAX_FS  = (FAST_LEN > SLOW_LEN) ? FAST_LEN : SLOW_LEN;
    localparam int MAX_LEN = (MAX_FS > DMA_LEN) ? MAX_FS : DMA_LEN;
    localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t FAST_LAST = cnt_t'(FAST_LEN - 1);
    localparam cnt_t SLOW_LAST = cnt_t'(SLOW_LEN - 1);
    localparam cnt_t DMA_LAST  = cnt_t'(DMA_LEN - 1);
    localparam cnt_t FAST_LO   = cnt_t'(FAST_LEN - FAST_ACT);
    localparam cnt_t SLOW_LO   = cnt_t'(SLOW_LEN - SLOW_ACT);
    localparam cnt_t DMA_LO    = cnt_t'(DMA_LEN - DMA_ACT);

    typedef struct packed {
        cnt_t      cnt;
        cyc_kind_e kind;
        logic      phi2;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    function automatic cnt_t last_of(input cyc_kind_e k);
        case (k)
            CYC_FAST: return FAST_LAST;
            CYC_DMA:  return DMA_LAST;
            default:  return SLOW_LAST;
        endcase
    endfunction

    // First count value of the high phase.
    function automatic cnt_t lo_of(input cyc_kind_e k);
        case (k)
            CYC_FAST: return FAST_LO;
            CYC_DMA:  return DMA_LO;
            default:  return SLOW_LO;
        endcase
    endfunction

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == last_of(tmr_q.kind)) begin
            tmr_d.cnt  = '0;
            tmr_d.kind = pick_kind(fast_i, dma_i);
        end else begin
            tmr_d.cnt  = tmr_q.cnt + cnt_t'(1);
        end
        tmr_d.phi2 = (tmr_d.cnt >= lo_of(tmr_d.kind));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmr_q.cnt  <= '0;
            tmr_q.kind <= CYC_SLOW;
            tmr_q.phi2 <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign phi2_o = tmr_q.phi2;

endmodule

// File: rtl/cbs_bank_latch.sv
module cbs_bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              phi2_i,
    input  logic [BANK_W-1:0] data_i,
    output logic [BANK_W-1:0] bank_o
);

    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (!phi2_i) begin
            bank_d = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_o = bank_q;

endmodule

// File: rtl/cbs_strobe_decode.sv
module cbs_strobe_decode
    import cbs_pkg::*;
(
    input  logic phi2_i,
    input  logic rwb_i,
    input  logic vda_i,
    input  logic vpa_i,
    output logic rd_n_o,
    output logic wr_n_o
);

    strobe_t stb_d;
    logic    mem_cycle;

    always_comb begin
        mem_cycle  = vda_i | vpa_i;
        stb_d.rd_n = 1'b1;
        stb_d.wr_n = 1'b1;
        if (phi2_i && mem_cycle) begin
            if (rwb_i) begin
                stb_d.rd_n = 1'b0;
            end else begin
                stb_d.wr_n = 1'b0;
            end
        end
    end

    assign rd_n_o = stb_d.rd_n;
    assign wr_n_o = stb_d.wr_n;

endmodule

// File: rtl/cpu_bus_strobe_gen.sv
module cpu_bus_strobe_gen #(
    parameter int FAST_LEN = 6,
    parameter int FAST_ACT = 3,
    parameter int SLOW_LEN = 8,
    parameter int SLOW_ACT = 3,
    parameter int DMA_LEN  = 8,
    parameter int DMA_ACT  = 4,
    parameter int OFFSET_W = 16,
    parameter int BANK_W   = 8,
    localparam int ADDR_W  = BANK_W + OFFSET_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                rwb_i,
    input  logic                vda_i,
    input  logic                vpa_i,
    input  logic [OFFSET_W-1:0] offset_i,
    input  logic [BANK_W-1:0]   data_i,
    input  logic                fast_i,
    input  logic                dma_i,
    output logic                phi2_o,
    output logic [BANK_W-1:0]   bank_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                rd_n_o,
    output logic                wr_n_o
);

    logic phi2;
    logic [BANK_W-1:0] bank;

    cbs_cycle_timer #(
        .FAST_LEN(FAST_LEN), .FAST_ACT(FAST_ACT),
        .SLOW_LEN(SLOW_LEN), .SLOW_ACT(SLOW_ACT),
        .DMA_LEN (DMA_LEN),  .DMA_ACT (DMA_ACT)
    ) u_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .fast_i(fast_i),
        .dma_i (dma_i),
        .phi2_o(phi2)
    );

    cbs_bank_latch #(.BANK_W(BANK_W)) u_bank (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .phi2_i(phi2),
        .data_i(data_i),
        .bank_o(bank)
    );

    cbs_strobe_decode u_stb (
        .phi2_i(phi2),
        .rwb_i (rwb_i),
        .vda_i (vda_i),
        .vpa_i (vpa_i),
        .rd_n_o(rd_n_o),
        .wr_n_o(wr_n_o)
    );

    assign phi2_o = phi2;
    assign bank_o = bank;
    assign addr_o = {bank, offset_i};

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int FAST_LEN = 6,
    parameter int FAST_ACT = 3,
    parameter int SLOW_LEN = 8,
    parameter int SLOW_ACT = 3,
    parameter int DMA_LEN  = 8,
    parameter int DMA_ACT  = 4,
    parameter int BANK_W   = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              phi2_o,
    input logic              rwb_i,
    input logic              vda_i,
    input logic              vpa_i,
    input logic [BANK_W-1:0] bank_o,
    input logic              rd_n_o,
    input logic              wr_n_o
);

    localparam int HI_FS  = (FAST_ACT > SLOW_ACT) ? FAST_ACT : SLOW_ACT;
    localparam int HI_MAX = (HI_FS > DMA_ACT) ? HI_FS : DMA_ACT;
    localparam int LO_F   = FAST_LEN - FAST_ACT;
    localparam int LO_S   = SLOW_LEN - SLOW_ACT;
    localparam int LO_D   = DMA_LEN - DMA_ACT;
    localparam int LO_FS  = (LO_F > LO_S) ? LO_F : LO_S;
    localparam int LO_MAX = (LO_FS > LO_D) ? LO_FS : LO_D;

    int unsigned hi_run, lo_run;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run <= 0;
            lo_run <= 0;
        end else if (phi2_o) begin
            hi_run <= hi_run + 1;
            lo_run <= 0;
        end else begin
            lo_run <= lo_run + 1;
            hi_run <= 0;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!phi2_o && rd_n_o && wr_n_o && bank_o == '0));

    p_high_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        hi_run <= HI_MAX);

    p_low_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        lo_run <= LO_MAX);

    p_rd_qualified_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_n_o |-> (phi2_o && rwb_i && (vda_i || vpa_i)));

    p_wr_qualified_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_n_o |-> (phi2_o && !rwb_i && (vda_i || vpa_i)));

    p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!vda_i && !vpa_i) |-> (rd_n_o && wr_n_o));

    p_bank_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(phi2_o) |-> $stable(bank_o));

endmodule

bind cpu_bus_strobe_gen cbs_checker #(
    .FAST_LEN(FAST_LEN), .FAST_ACT(FAST_ACT),
    .SLOW_LEN(SLOW_LEN), .SLOW_ACT(SLOW_ACT),
    .DMA_LEN (DMA_LEN),  .DMA_ACT (DMA_ACT),
    .BANK_W  (BANK_W)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .phi2_o(phi2_o),
    .rwb_i (rwb_i),
    .vda_i (vda_i),
    .vpa_i (vpa_i),
    .bank_o(bank_o),
    .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o)
);

// File: tb/sim_cpu_bus_strobe_gen.sv
module sim_cpu_bus_strobe_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        rwb, vda, vpa, fast, dma;
    logic [15:0] offset;
    logic [7:0]  data;
    logic        phi2, rd_n, wr_n;
    logic [7:0]  bank;
    logic [23:0] addr;

    int checks = 0;
    int errors = 0;
    int rd_lo, rd_hi, wr_lo, wr_hi;
    bit done = 0;

    always #4 clk = ~clk;

    cpu_bus_strobe_gen u0 (
        .clk_i(clk), .rst_i(rst), .rwb_i(rwb), .vda_i(vda), .vpa_i(vpa),
        .offset_i(offset), .data_i(data), .fast_i(fast), .dma_i(dma),
        .phi2_o(phi2), .bank_o(bank), .addr_o(addr), .rd_n_o(rd_n), .wr_n_o(wr_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Starts at a low sample; ends at the first low sample of the next cycle.
    task automatic count_phases(output int lo, output int hi);
        lo = 0; hi = 0; rd_lo = 0; rd_hi = 0; wr_lo = 0; wr_hi = 0;
        while (phi2 == 1'b0 && lo < 20) begin
            lo++;
            if (!rd_n) rd_lo++;
            if (!wr_n) wr_lo++;
            @(negedge clk);
        end
        while (phi2 == 1'b1 && hi < 20) begin
            hi++;
            if (!rd_n) rd_hi++;
            if (!wr_n) wr_hi++;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input bit f, input bit d, input bit r, input bit a, input bit p,
                           input int exp_lo, input int exp_hi, input bit exp_rd,
                           input bit exp_wr, input string tag);
        int lo, hi;
        fast = f; dma = d; rwb = r; vda = a; vpa = p;
        count_phases(lo, hi);
        count_phases(lo, hi);
        chk({tag, " low phase"}, lo, exp_lo);
        chk({tag, " high phase"}, hi, exp_hi);
        chk({tag, " R6 rd in high"}, rd_hi, exp_rd ? exp_hi : 0);
        chk({tag, " R7 wr in high"}, wr_hi, exp_wr ? exp_hi : 0);
        chk({tag, " R6 R7 no strobe in low"}, rd_lo + wr_lo, 0);
    endtask

    task automatic test_reset();
        int lo, hi;
        rst = 1'b1; rwb = 1'b1; vda = 1'b1; vpa = 1'b0; fast = 1'b0; dma = 1'b0;
        offset = 16'h0000; data = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R1 phi2 in reset", phi2, 0);
        chk("R1 rd_n in reset", rd_n, 1);
        chk("R1 wr_n in reset", wr_n, 1);
        chk("R1 bank in reset", bank, 0);
        rst = 1'b0;
        count_phases(lo, hi);
        chk("R1 R3 first cycle low", lo, 5);
        chk("R1 R3 first cycle high", hi, 3);
    endtask

    task automatic test_midcycle();
        int lo, hi;
        fast = 1'b1; dma = 1'b0; rwb = 1'b1; vda = 1'b1; vpa = 1'b0;
        count_phases(lo, hi);
        fast = 1'b0;
        count_phases(lo, hi);
        chk("R5 fast kept low", lo, 3);
        chk("R5 fast kept high", hi, 3);
        dma = 1'b1;
        count_phases(lo, hi);
        chk("R5 slow after drop low", lo, 5);
        chk("R5 slow after drop high", hi, 3);
        count_phases(lo, hi);
        chk("R5 dma next low", lo, 4);
        chk("R5 dma next high", hi, 4);
        dma = 1'b0;
    endtask

    task automatic test_bank();
        int lo, hi;
        fast = 1'b0; dma = 1'b0;
        count_phases(lo, hi);
        data = 8'hA5; offset = 16'h1234;
        while (phi2 == 1'b0) @(negedge clk);
        chk("R9 bank at first high", bank, 8'hA5);
        chk("R10 addr at first high", addr, 24'hA51234);
        data = 8'h3C; offset = 16'hBEEF;
        @(negedge clk);
        while (phi2 == 1'b1) begin
            chk("R9 bank held in high", bank, 8'hA5);
            chk("R10 addr follows offset", addr, 24'hA5BEEF);
            @(negedge clk);
        end
        chk("R9 bank before low capture", bank, 8'hA5);
        @(negedge clk);
        chk("R9 bank after low capture", bank, 8'h3C);
        chk("R10 addr after capture", addr, 24'h3CBEEF);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        run_cfg(1, 0, 1, 1, 0, 3, 3, 1, 0, "R2 fast read");
        run_cfg(0, 0, 0, 0, 1, 5, 3, 0, 1, "R3 slow write");
        run_cfg(0, 1, 1, 0, 1, 4, 4, 1, 0, "R4 dma read");
        run_cfg(1, 1, 0, 1, 1, 4, 4, 0, 1, "R4 dma over fast write");
        run_cfg(1, 0, 1, 0, 0, 3, 3, 0, 0, "R8 internal rwb1");
        run_cfg(0, 0, 0, 0, 0, 5, 3, 0, 0, "R8 internal rwb0");
        test_midcycle();
        test_bank();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule